// File: doc/BRIEF.md
# External Memory Wait-State Sequencer

This block is the bus-master side of an asynchronous external memory port. An internal client presents one request at a time (address, direction, write data). The sequencer decodes the target bank from the top address bits, raises that bank's select line, pulses a read or write strobe for a length set by the bank's wait configuration, and finishes with a one-cycle done pulse that carries read data back to the client.

Each bank has a wait count and a wait mode. In the fixed mode the strobe length depends on the count alone. In the acknowledge mode the external device decides the length by raising an acknowledge input. In the combined mode the count runs first and the acknowledge is heeded only afterwards. Two optional one-cycle gaps can be enabled: an address-hold cycle that keeps select and address valid after the strobe falls, and a bus-idle cycle that follows reads only.

Top module: `ext_wait_seq`

## Requirements
- R1: Bank index is reqAddr[23:22]; while an access has its strobe or hold cycle, memSel carries exactly bit (bank index) high, and memSel is all zero otherwise.
- R2: reqReady is high only while the sequencer is idle; a request is taken at a rising edge with reqValid and reqReady high, and the strobe of that access is asserted in the very next cycle.
- R3: Wait mode 2'b00 (fixed): the strobe lasts exactly 1 + W cycles, W being the bank's 3-bit count in waitCount[3*b +: 3]; memAck has no effect.
- R4: Wait mode 2'b01 (acknowledge): memAck is sampled from the first strobe cycle; the strobe ends after the first cycle in which memAck is high, and W has no effect.
- R5: Wait modes 2'b10 and 2'b11 (combined): memAck is ignored during the first W strobe cycles; the strobe ends after the first later cycle with memAck high; with W = 0 memAck is heeded from the first cycle.
- R6: doneValid is a one-cycle pulse in the cycle after the last strobe cycle; for a read, rdData then holds memDataIn as sampled at the edge that ends the last strobe cycle.
- R7: During a write, memDataOe is high and memDataOut equals the request's write data for every strobe and hold cycle; during a read memDataOe is low; memRdStb and memWrStb are never high together.
- R8: With holdEn high, one cycle follows the strobe in which both strobes are low while memSel and memAddr stay valid.
- R9: With idleEn high, one cycle with no select, no strobe and reqReady low follows every read (after its hold cycle if any); writes get no idle cycle.
- R10: memAddr stays equal to the request address for the whole strobe and hold phase.
- R11: After reset: no select, both strobes low, doneValid low, memDataOe low, reqReady high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Client request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Request address, top two bits pick the bank |
| reqWrData | input | 32 | Write data |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| doneValid | output | 1 | Access finished pulse |
| rdData | output | 32 | Captured read data |
| waitCount | input | 12 | Per-bank 3-bit wait count |
| waitMode | input | 8 | Per-bank 2-bit wait mode |
| holdEn | input | 1 | Enable address-hold cycle |
| idleEn | input | 1 | Enable bus-idle cycle after reads |
| memAck | input | 1 | External acknowledge |
| memSel | output | 4 | One select per bank, active high |
| memAddr | output | 24 | External address |
| memDataOut | output | 32 | Data driven on writes |
| memDataOe | output | 1 | Data output enable |
| memDataIn | input | 32 | Data returned on reads |
| memRdStb | output | 1 | Read strobe, active high |
| memWrStb | output | 1 | Write strobe, active high |

## Verification
The two functions that collide in one cycle are the end of the wait count and the arrival of the acknowledge, and, separately, the done pulse with the hold cycle. The bench drives memAck high from a chosen strobe cycle onward and places that cycle before, on and after the count boundary in each mode, then judges the measured strobe length against 1 + W, the acknowledge cycle, or the larger of the two. The returned data changes on the last strobe cycle only, so a capture one cycle early or late shows as wrong read data, and the done pulse is checked to land in the same cycle as the hold cycle.

// File: rtl/ext_wait_pkg.sv
package ext_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_GAP    = 2'd3
  } seqState_t;

  localparam logic [1:0] MODE_FIXED = 2'b00;
  localparam logic [1:0] MODE_ACK   = 2'b01;

  typedef struct packed {
    logic loadReq;    // latch the accepted request
    logic capture;    // sample read data this edge
    logic addrValid;  // strobe or hold phase
  } dpCtl_t;
endpackage

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
  import ext_wait_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int WAIT_W = 3,
  localparam int BANK_BITS = $clog2(BANKS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [BANK_BITS-1:0]    reqBank,
  input  logic [BANKS*WAIT_W-1:0] waitCount,
  input  logic [BANKS*2-1:0]      waitMode,
  input  logic                    holdEn,
  input  logic                    idleEn,
  input  logic                    memAck,
  output logic                    reqReady,
  output logic                    doneValid,
  output logic                    memRdStb,
  output logic                    memWrStb,
  output dpCtl_t                  strb
);
  seqState_t state, stateNext;
  logic [WAIT_W-1:0] cnt, waitQ;
  logic [1:0]        modeQ;
  logic              writeQ;
  logic              waitsDone, endStrobe, accept, afterStrobeGap;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign waitsDone = (cnt >= waitQ);

  always_comb begin
    case (modeQ)
      MODE_FIXED: endStrobe = waitsDone;
      MODE_ACK:   endStrobe = memAck;
      default:    endStrobe = waitsDone && memAck;
    endcase
  end

  assign afterStrobeGap = idleEn && !writeQ;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept) stateNext = ST_STROBE;
      ST_STROBE: if (endStrobe)
                   stateNext = holdEn ? ST_HOLD : (afterStrobeGap ? ST_GAP : ST_IDLE);
      ST_HOLD:   stateNext = afterStrobeGap ? ST_GAP : ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      waitQ     <= '0;
      modeQ     <= MODE_FIXED;
      writeQ    <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= (state == ST_STROBE) && endStrobe;
      if (accept) begin
        cnt    <= '0;
        waitQ  <= waitCount[reqBank*WAIT_W +: WAIT_W];
        modeQ  <= waitMode[reqBank*2 +: 2];
        writeQ <= reqWrite;
      end else if (state == ST_STROBE && cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign reqReady       = (state == ST_IDLE);
  assign memRdStb       = (state == ST_STROBE) && !writeQ;
  assign memWrStb       = (state == ST_STROBE) && writeQ;
  assign strb.loadReq   = accept;
  assign strb.capture   = (state == ST_STROBE) && endStrobe && !writeQ;
  assign strb.addrValid = (state == ST_STROBE) || (state == ST_HOLD);

  assert_excl_strobes_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdStb && memWrStb));
  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdStb || memWrStb) |-> !reqReady);
  assert_done_follows_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(memRdStb || memWrStb));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: rtl/ext_wait_dp.sv
module ext_wait_dp
  import ext_wait_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BANKS  = 4,
  localparam int BANK_BITS = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [BANKS-1:0]  memSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic                 writeQ;
  logic [BANK_BITS-1:0] bankQ;

  assign bankQ = addrQ[ADDR_W-1 -: BANK_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      writeQ <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.loadReq) begin
        addrQ  <= reqAddr;
        dataQ  <= reqWrData;
        writeQ <= reqWrite;
      end
      if (strb.capture) rdData <= memDataIn;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : gSel
    assign memSel[g] = strb.addrValid && (bankQ == BANK_BITS'(g));
  end

  assign memAddr    = addrQ;
  assign memDataOut = dataQ;
  assign memDataOe  = strb.addrValid && writeQ;

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memSel));
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrValid && $past(strb.addrValid)) |-> $stable(memAddr));
endmodule

// File: rtl/ext_wait_seq.sv
module ext_wait_seq
  import ext_wait_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BANKS  = 4,
  parameter int WAIT_W = 3,
  localparam int BANK_BITS = $clog2(BANKS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWrData,
  output logic                    reqReady,
  output logic                    doneValid,
  output logic [DATA_W-1:0]       rdData,
  input  logic [BANKS*WAIT_W-1:0] waitCount,
  input  logic [BANKS*2-1:0]      waitMode,
  input  logic                    holdEn,
  input  logic                    idleEn,
  input  logic                    memAck,
  output logic [BANKS-1:0]        memSel,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memDataOut,
  output logic                    memDataOe,
  input  logic [DATA_W-1:0]       memDataIn,
  output logic                    memRdStb,
  output logic                    memWrStb
);
  dpCtl_t strb;

  ext_wait_ctrl #(.BANKS(BANKS), .WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqAddr[ADDR_W-1 -: BANK_BITS]), .waitCount(waitCount),
    .waitMode(waitMode), .holdEn(holdEn), .idleEn(idleEn), .memAck(memAck),
    .reqReady(reqReady), .doneValid(doneValid), .memRdStb(memRdStb),
    .memWrStb(memWrStb), .strb(strb)
  );

  ext_wait_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .memDataIn(memDataIn),
    .memSel(memSel), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .rdData(rdData)
  );
endmodule

// File: tb/ext_wait_seq_test.sv
module ext_wait_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWrData = '0, memDataIn = '0;
  logic [11:0] waitCount;
  logic [7:0]  waitMode;
  logic        holdEn = 1'b0, idleEn = 1'b0, memAck = 1'b0;
  logic        reqReady, doneValid, memDataOe, memRdStb, memWrStb;
  logic [31:0] rdData, memDataOut;
  logic [3:0]  memSel;
  logic [23:0] memAddr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  // bank0: W=2 fixed, bank1: W=5 ack, bank2: W=3 combined, bank3: W=0 combined(11)
  assign waitCount = {3'd0, 3'd3, 3'd5, 3'd2};
  assign waitMode  = {2'b11, 2'b10, 2'b01, 2'b00};

  ext_wait_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqReady(reqReady),
    .doneValid(doneValid), .rdData(rdData), .waitCount(waitCount),
    .waitMode(waitMode), .holdEn(holdEn), .idleEn(idleEn), .memAck(memAck),
    .memSel(memSel), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .memRdStb(memRdStb),
    .memWrStb(memWrStb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runAccess(input bit wr, input logic [23:0] addr,
                           input logic [31:0] data, input int ackAt,
                           input int expLen, input bit hold, input bit idle,
                           input string tag);
    logic [3:0] expSel = 4'b0001 << addr[23:22];
    int len = 0;
    holdEn = hold; idleEn = idle;
    @(negedge clk);
    chk(reqReady === 1'b1, {"R2 ready ", tag}, 32'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWrData = data;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~addr; reqWrData = ~data;
    chk((memRdStb | memWrStb) === 1'b1, {"R2 strobe next cycle ", tag},
        32'(memRdStb | memWrStb), 1);
    while ((memRdStb || memWrStb) && len < 40) begin
      len++;
      chk(memSel === expSel, {"R1 select ", tag}, 32'(memSel), 32'(expSel));
      chk(memAddr === addr, {"R10 address ", tag}, 32'(memAddr), 32'(addr));
      chk(!reqReady, {"R2 busy ", tag}, 32'(reqReady), 0);
      chk(memWrStb === wr && memRdStb === !wr, {"R7 strobe kind ", tag},
          32'({memWrStb, memRdStb}), 32'({wr, !wr}));
      chk(memDataOe === wr, {"R7 oe ", tag}, 32'(memDataOe), 32'(wr));
      if (wr) chk(memDataOut === data, {"R7 wdata ", tag}, memDataOut, data);
      memDataIn = (len == expLen) ? data : ~data;
      memAck = (len >= ackAt);
      @(negedge clk);
    end
    memAck = 1'b0; memDataIn = '0;
    chk(len == expLen, {"R3/R4/R5 strobe length ", tag}, 32'(len), 32'(expLen));
    chk(doneValid === 1'b1, {"R6 done ", tag}, 32'(doneValid), 1);
    if (!wr) chk(rdData === data, {"R6 rdata ", tag}, rdData, data);
    if (hold) begin
      chk(memSel === expSel && !memRdStb && !memWrStb, {"R8 hold ", tag},
          32'(memSel), 32'(expSel));
      chk(memAddr === addr, {"R8 hold addr ", tag}, 32'(memAddr), 32'(addr));
      if (wr) chk(memDataOe === 1'b1, {"R7 hold oe ", tag}, 32'(memDataOe), 1);
      @(negedge clk);
      chk(doneValid === 1'b0, {"R6 single pulse ", tag}, 32'(doneValid), 0);
    end else if (!(idle && !wr)) begin
      chk(memSel === 4'b0, {"R1 released ", tag}, 32'(memSel), 0);
    end
    if (idle && !wr) begin
      chk(memSel === 4'b0 && !reqReady && !memRdStb, {"R9 idle gap ", tag},
          32'({memSel, reqReady}), 0);
      @(negedge clk);
    end
    chk(reqReady === 1'b1 && memSel === 4'b0, {"R2/R9 back to idle ", tag},
        32'({memSel, reqReady}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(memSel === 4'b0 && !memRdStb && !memWrStb && !doneValid && !memDataOe,
        "R11 reset outputs", 32'({memSel, memRdStb, memWrStb, doneValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R11 ready after reset", 32'(reqReady), 1);
    // R3 fixed mode, memAck high from the start must not shorten it
    runAccess(1'b0, 24'h012345, 32'hA5A5_0001, 1, 3, 1'b0, 1'b0, "fixed rd");
    runAccess(1'b1, 24'h0000F0, 32'h1234_5678, 1, 3, 1'b1, 1'b0, "fixed wr hold");
    // R4 acknowledge mode, W=5 ignored
    runAccess(1'b0, 24'h4ABCDE, 32'hBEEF_0002, 2, 2, 1'b0, 1'b0, "ack rd");
    runAccess(1'b1, 24'h7FFFFF, 32'hCAFE_0003, 4, 4, 1'b0, 1'b1, "ack wr no gap");
    runAccess(1'b0, 24'h400000, 32'h0BAD_0004, 1, 1, 1'b0, 1'b0, "ack first cycle");
    // R5 combined mode, W=3
    runAccess(1'b0, 24'h8F0F0F, 32'h5555_0005, 1, 4, 1'b0, 1'b1, "both early ack");
    runAccess(1'b0, 24'h800010, 32'h6666_0006, 6, 6, 1'b1, 1'b1, "both late ack");
    runAccess(1'b0, 24'hBFFFFF, 32'h7777_0007, 4, 4, 1'b0, 1'b0, "both ack at boundary");
    // R5 combined W=0 (mode 11)
    runAccess(1'b1, 24'hC00010, 32'h8888_0008, 1, 1, 1'b0, 1'b1, "both w0 wr");
    runAccess(1'b0, 24'hFFFFFE, 32'h9999_0009, 3, 3, 1'b1, 1'b0, "both w0 rd late");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule